// File: doc/BRIEF.md
# CPU core power-up sequencer

This block brings a single processor core out of power collapse. One start pulse launches a fixed, ordered series of writes. The first write goes to a voltage-rail control byte. All later writes go to a power-control word. Between writes, the block waits for a time given in nanoseconds. A down-counter produces that wait, and the cycle count comes from the `CLK_FREQ_HZ` parameter.

The order in which the clamps and resets are released is interleaved, and each step has its own wait:

1. The core rail is turned on.
2. Clamps are raised with the L2 array held in sleep.
3. L2 sleep is released.
4. Core power-on reset is pulsed around the release of the output clamp.
5. The core is marked as powered up.

A busy flag and a done flag form the handshake for the caller.

Top module: `core_pwrup_seq`

## Requirements
- R1: After reset, `rail_ctl_o` and `pwr_ctl_o` are zero and `busy_o` and `done_o` are low.
- R2: A start pulse sampled high while idle sets `rail_ctl_o` to 0xA4, raises `busy_o` and clears `done_o`, all at that same clock edge.
- R3: `ceil(512 us)` cycles after the rail write, `pwr_ctl_o` becomes 0x109. This sets bit 8 (PLL clamp), bit 3 (L2 data sleep) and bit 0 (output clamp). One cycle later it becomes 0x101, which clears bit 3.
- R4: `ceil(300 ns)` cycles after the 0x101 write, bit 5 (core power-on reset) is added, giving 0x121.
- R5: `ceil(2 us)` cycles later, bit 0 is cleared, giving 0x120.
- R6: `ceil(2 us)` cycles later, bit 5 is cleared, giving 0x100.
- R7: `ceil(100 us)` cycles later, bit 7 (core powered up) is set with bit 8 kept, giving 0x180. At that same edge `busy_o` falls and `done_o` rises. `busy_o` and `done_o` are never high together.
- R8: Bit 4 (core reset) of `pwr_ctl_o` is never driven high.
- R9: Each wait lasts `ceil(t_ns * CLK_FREQ_HZ / 1e9)` clock cycles, with a minimum of one cycle, so no wait is shorter than its required time.
- R10: A start pulse sampled while `busy_o` is high has no effect on any output or on the step timing.
- R11: `done_o` stays high until the next accepted start pulse, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| rail_ctl_o | output | RAIL_W | Voltage-rail control byte |
| pwr_ctl_o | output | PWR_W | Power-control word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last step written; held until the next start |

## Verification
A wrong step index or counter value shows up on `pwr_ctl_o` at the first write boundary it affects. A skipped or repeated step changes the word immediately. An off-by-one in the delay load moves that boundary by exactly one cycle. For this reason every output is compared in every cycle of two full runs against a schedule the bench derives on its own from the clock frequency. Any deviation is caught in the cycle it occurs. Start requests are injected mid-wait and on the final edge, and a start held high for several cycles is applied, to show that a busy-time start neither restarts nor shifts the schedule.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;

  localparam int unsigned BIT_PLL_CLAMP = 8;
  localparam int unsigned BIT_PWRD_UP   = 7;
  localparam int unsigned BIT_POR       = 5;
  localparam int unsigned BIT_CORE_RST  = 4;
  localparam int unsigned BIT_L2_SLP    = 3;
  localparam int unsigned BIT_CLAMP     = 0;

  localparam longint unsigned NS_RAIL   = 512_000;
  localparam longint unsigned NS_SETTLE = 300;
  localparam longint unsigned NS_POR    = 2_000;
  localparam longint unsigned NS_PWRUP  = 100_000;

  typedef enum logic [2:0] {
    ST_RAIL_ON   = 3'd0,
    ST_CLAMP_ALL = 3'd1,
    ST_L2_WAKE   = 3'd2,
    ST_POR_SET   = 3'd3,
    ST_CLAMP_REL = 3'd4,
    ST_POR_REL   = 3'd5,
    ST_PWRD_UP   = 3'd6
  } step_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic longint unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic longint unsigned max_delay(longint unsigned hz);
    longint unsigned m;
    m = ns_to_cycles(NS_RAIL, hz);
    if (ns_to_cycles(NS_PWRUP, hz) > m) m = ns_to_cycles(NS_PWRUP, hz);
    if (ns_to_cycles(NS_POR, hz) > m) m = ns_to_cycles(NS_POR, hz);
    if (ns_to_cycles(NS_SETTLE, hz) > m) m = ns_to_cycles(NS_SETTLE, hz);
    return m;
  endfunction

endpackage

// File: rtl/core_pwrup_timer.sv
module core_pwrup_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  // load N-1 so the next action lands exactly N edges after the load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i - CNT_W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  AST_TMR_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> load_val_i != '0); // R9
  AST_TMR_EXPIRE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !load_i |=> expired_o); // R9

endmodule

// File: rtl/core_pwrup_step_rom.sv
module core_pwrup_step_rom
  import core_pwrup_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ  = 50_000_000,
  parameter int unsigned     PWR_W        = 32,
  parameter int unsigned     RAIL_W       = 8,
  parameter int unsigned     CNT_W        = 16,
  parameter logic [RAIL_W-1:0] RAIL_ON_CODE = 8'hA4
) (
  input  logic [2:0]        step_i,
  output logic              is_rail_o,
  output logic [RAIL_W-1:0] rail_val_o,
  output logic [PWR_W-1:0]  pwr_val_o,
  output logic [CNT_W-1:0]  delay_o,
  output logic              last_o
);

  localparam logic [PWR_W-1:0] M_PLL   = PWR_W'(1) << BIT_PLL_CLAMP;
  localparam logic [PWR_W-1:0] M_PWRD  = PWR_W'(1) << BIT_PWRD_UP;
  localparam logic [PWR_W-1:0] M_POR   = PWR_W'(1) << BIT_POR;
  localparam logic [PWR_W-1:0] M_L2    = PWR_W'(1) << BIT_L2_SLP;
  localparam logic [PWR_W-1:0] M_CLAMP = PWR_W'(1) << BIT_CLAMP;

  localparam logic [CNT_W-1:0] D_RAIL   = CNT_W'(ns_to_cycles(NS_RAIL,   CLK_FREQ_HZ));
  localparam logic [CNT_W-1:0] D_SETTLE = CNT_W'(ns_to_cycles(NS_SETTLE, CLK_FREQ_HZ));
  localparam logic [CNT_W-1:0] D_POR    = CNT_W'(ns_to_cycles(NS_POR,    CLK_FREQ_HZ));
  localparam logic [CNT_W-1:0] D_PWRUP  = CNT_W'(ns_to_cycles(NS_PWRUP,  CLK_FREQ_HZ));

  always_comb begin
    is_rail_o  = 1'b0;
    rail_val_o = '0;
    pwr_val_o  = '0;
    delay_o    = CNT_W'(1);
    last_o     = 1'b0;
    unique case (step_e'(step_i))
      ST_RAIL_ON: begin
        is_rail_o  = 1'b1;
        rail_val_o = RAIL_ON_CODE;
        delay_o    = D_RAIL;
      end
      ST_CLAMP_ALL: pwr_val_o = M_PLL | M_L2 | M_CLAMP;
      ST_L2_WAKE: begin
        pwr_val_o = M_PLL | M_CLAMP;
        delay_o   = D_SETTLE;
      end
      ST_POR_SET: begin
        pwr_val_o = M_PLL | M_CLAMP | M_POR;
        delay_o   = D_POR;
      end
      ST_CLAMP_REL: begin
        pwr_val_o = M_PLL | M_POR;
        delay_o   = D_POR;
      end
      ST_POR_REL: begin
        pwr_val_o = M_PLL;
        delay_o   = D_PWRUP;
      end
      ST_PWRD_UP: begin
        pwr_val_o = M_PLL | M_PWRD;
        last_o    = 1'b1;
      end
      default: begin
        pwr_val_o = M_PLL | M_PWRD;
        last_o    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import core_pwrup_pkg::*;
#(
  parameter longint unsigned   CLK_FREQ_HZ  = 50_000_000,
  parameter int unsigned       PWR_W        = 32,
  parameter int unsigned       RAIL_W       = 8,
  parameter logic [RAIL_W-1:0] RAIL_ON_CODE = 8'hA4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [RAIL_W-1:0] rail_ctl_o,
  output logic [PWR_W-1:0]  pwr_ctl_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned CNT_W = $clog2(max_delay(CLK_FREQ_HZ) + 1);

  logic [2:0]        cur_q;
  logic              busy_q, done_q;
  logic [RAIL_W-1:0] rail_q;
  logic [PWR_W-1:0]  pwr_q;

  logic [2:0]        rom_step;
  logic              rom_is_rail, rom_last;
  logic [RAIL_W-1:0] rom_rail;
  logic [PWR_W-1:0]  rom_pwr;
  logic [CNT_W-1:0]  rom_delay;
  logic              tmr_expired, tmr_load;
  logic              accept, advance, apply;

  assign accept   = start_i & ~busy_q;
  assign advance  = busy_q & tmr_expired;
  assign apply    = accept | advance;
  assign rom_step = busy_q ? cur_q + 3'd1 : 3'(ST_RAIL_ON);
  assign tmr_load = apply & ~rom_last;

  core_pwrup_step_rom #(
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .PWR_W       (PWR_W),
    .RAIL_W      (RAIL_W),
    .CNT_W       (CNT_W),
    .RAIL_ON_CODE(RAIL_ON_CODE)
  ) u_rom (
    .step_i    (rom_step),
    .is_rail_o (rom_is_rail),
    .rail_val_o(rom_rail),
    .pwr_val_o (rom_pwr),
    .delay_o   (rom_delay),
    .last_o    (rom_last)
  );

  core_pwrup_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(rom_delay),
    .expired_o (tmr_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rail_q <= '0;
      pwr_q  <= '0;
    end else if (apply) begin
      cur_q <= rom_step;
      if (rom_is_rail) rail_q <= rom_rail;
      else             pwr_q  <= rom_pwr;
      if (accept) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (rom_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign rail_ctl_o = rail_q;
  assign pwr_ctl_o  = pwr_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  AST_CORE_RST_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q[BIT_CORE_RST]); // R8
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q)); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !tmr_expired |=> busy_q && $stable(pwr_q) && $stable(rail_q)); // R10
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !start_i |=> done_q); // R11
  AST_PWRD_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q[BIT_PWRD_UP]) |-> pwr_q[BIT_PLL_CLAMP] && $fell(busy_q)); // R7
  AST_POR_UNDER_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q[BIT_POR] |-> pwr_q[BIT_PLL_CLAMP]); // R5

endmodule

// File: tb/sim_core_pwrup_seq.sv
module sim_core_pwrup_seq;

  localparam longint unsigned CLK_HZ = 50_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rail;
  logic [31:0] pwr;
  logic        busy, done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  core_pwrup_seq #(.CLK_FREQ_HZ(CLK_HZ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rail_ctl_o(rail), .pwr_ctl_o(pwr), .busy_o(busy), .done_o(done)
  );

  // R9: ceil of time times frequency, at least one cycle
  function automatic int cyc(longint unsigned ns);
    longint unsigned c;
    c = (ns * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  int e1, e2, e3, e4, e5, e6;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic string seg_tag(int k);
    if (k < e1) return "R2";
    if (k < e3) return "R3";
    if (k < e4) return "R4";
    if (k < e5) return "R5";
    if (k < e6) return "R6";
    return "R7";
  endfunction

  function automatic logic [31:0] exp_word(int k, logic [31:0] prev);
    if (k < e1) return prev;
    if (k < e2) return 32'h109;
    if (k < e3) return 32'h101;
    if (k < e4) return 32'h121;
    if (k < e5) return 32'h120;
    if (k < e6) return 32'h100;
    return 32'h180;
  endfunction

  // k counts edges from the accepting edge (k=0); sampling at the negedge after edge k
  task automatic run_seq(logic [31:0] prev, int hold);
    logic ign;
    ign = 1'b0;
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k <= e6 + 10; k++) begin
      @(negedge clk);
      begin
        string t;
        t = ign ? "R10" : seg_tag(k);
        check({t, " rail"}, {24'd0, rail}, 32'hA4);
        check({t, " word"}, pwr, exp_word(k, prev));
        check({t, " busy"}, {31'd0, busy}, {31'd0, k < e6});
        check(ign ? "R10 done" : "R11 done", {31'd0, done}, {31'd0, k >= e6});
        check("R8 core reset bit", {31'd0, pwr[4]}, 32'd0);
      end
      ign = (k < hold) || k == 5 || k == e1 - 1 || k == e3 || k == e6 - 1;
      start = ign;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    e1 = cyc(512_000);
    e2 = e1 + 1;
    e3 = e2 + cyc(300);
    e4 = e3 + cyc(2_000);
    e5 = e4 + cyc(2_000);
    e6 = e5 + cyc(100_000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state held while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 rail", {24'd0, rail}, 32'd0);
      check("R1 word", pwr, 32'd0);
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 done", {31'd0, done}, 32'd0);
    end
    run_seq(32'h0, 0);
    // second run: start held three cycles, extra edges must be ignored (R10); done cleared (R11)
    run_seq(32'h180, 3);
    summary();
  end

endmodule